// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 32-bit binary operands and an incoming carry in one combinational pass. It returns the 32-bit sum, the carry leaving the top bit, and a flag that marks two's complement overflow. There are no clocks or registers, so the outputs follow the inputs within the same evaluation.

The operand width is cut into four groups of eight bits. Each bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). Inside a group, every internal carry is a flat sum-of-products of these terms and the carry entering the group. Each group also reports one group generate and one group propagate to a second lookahead level. That level turns these pairs and the incoming carry into the carry entering each group and the final carry-out.

A compile-time parameter can replace the second level with a plain chain, in which each group's own top carry feeds the next group. Lookahead is still used inside each group. Both arrangements give the same outputs for every input.

Top module: `cla_add2l`

## Requirements
- R1: `sum_o` equals the low 32 bits of `opa_i + opb_i + cin_i`, read as unsigned numbers.
- R2: `cout_o` equals bit 32 of the unsigned sum `opa_i + opb_i + cin_i`.
- R3: `ovf_o` is 1 exactly when both operands have the same bit 31 and `sum_o` bit 31 differs from it. This is the carry into bit 31 XOR the carry out of bit 31.
- R4: When an 8-bit group generates a carry by itself, the carry entering the next group is 1 whatever the lower bits and `cin_i` hold. With `RIPPLE_GRP` = 0 that carry comes from the second lookahead level, and it equals the top carry formed inside the group.
- R5: When every bit position propagates and `cin_i` is 1, the carry crosses all group boundaries and `cout_o` is 1. One case: all-ones plus zero with carry-in 1 gives sum 0 and carry-out 1.
- R6: With both operands zero, `sum_o` equals `cin_i` and `cout_o` and `ovf_o` are 0.
- R7: Builds with `RIPPLE_GRP` = 1 (group-to-group ripple) and with `RIPPLE_GRP` = 0 (second-level lookahead) give identical `sum_o`, `cout_o` and `ovf_o` for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Sum bits |
| cout_o | output | 1 | Carry out of bit 31 |
| ovf_o | output | 1 | Two's complement overflow |

## Verification
The immediate assertions inside the adder assume that every input bit holds a known 0 or 1. Each check is skipped while any operand bit is unknown, so the undriven start of a run does not trip them. The bench drives both operands and the carry-in with defined values from the first step, and it never releases them. Random operands come from `$urandom` with a fixed seed. Directed patterns are added so that carries run through every group boundary and overflow occurs in both directions.

// File: rtl/cla_add2l.sv
module cla_add2l #(
  parameter int WIDTH      = 32,
  parameter int GRP_W      = 8,
  parameter bit RIPPLE_GRP = 1'b0
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int NGRP = WIDTH / GRP_W;

  // carry out of local position k: flat sum-of-products, no internal chain
  function automatic logic grp_carry(input logic [GRP_W-1:0] g, input logic [GRP_W-1:0] p,
                                     input logic ci, input int k);
    logic res, term;
    res = 1'b0;
    for (int m = -1; m < GRP_W; m++) begin
      if (m <= k) begin
        term = (m < 0) ? ci : g[m];
        for (int n = 0; n < GRP_W; n++)
          if (n > m && n <= k) term = term & p[n];
        res = res | term;
      end
    end
    return res;
  endfunction

  function automatic logic top_carry(input logic [NGRP-1:0] g, input logic [NGRP-1:0] p,
                                     input logic ci, input int k);
    logic res, term;
    res = 1'b0;
    for (int m = -1; m < NGRP; m++) begin
      if (m <= k) begin
        term = (m < 0) ? ci : g[m];
        for (int n = 0; n < NGRP; n++)
          if (n > m && n <= k) term = term & p[n];
        res = res | term;
      end
    end
    return res;
  endfunction

  logic [WIDTH-1:0] gen, prp, cin_bit;
  logic [NGRP-1:0]  grp_g, grp_p, grp_co;
  logic [NGRP:0]    grp_ci;

  assign gen = opa_i & opb_i;
  assign prp = opa_i | opb_i;
  assign grp_ci[0] = cin_i;

  for (genvar j = 0; j < NGRP; j++) begin : g_grp
    logic [GRP_W-1:0] lg, lp;
    logic [GRP_W:0]   lc;
    assign lg = gen[j*GRP_W +: GRP_W];
    assign lp = prp[j*GRP_W +: GRP_W];
    assign lc[0] = grp_ci[j];
    for (genvar k = 0; k < GRP_W; k++) begin : g_bit
      assign lc[k+1] = grp_carry(lg, lp, grp_ci[j], k);
    end
    assign grp_g[j]  = grp_carry(lg, lp, 1'b0, GRP_W-1);
    assign grp_p[j]  = &lp;
    assign grp_co[j] = lc[GRP_W];
    assign cin_bit[j*GRP_W +: GRP_W] = lc[GRP_W-1:0];
    assign sum_o[j*GRP_W +: GRP_W]   = opa_i[j*GRP_W +: GRP_W] ^ opb_i[j*GRP_W +: GRP_W] ^ lc[GRP_W-1:0];

    if (RIPPLE_GRP) begin : g_rip
      assign grp_ci[j+1] = grp_co[j];
    end else begin : g_la
      assign grp_ci[j+1] = top_carry(grp_g, grp_p, cin_i, j);
      // R4: second-level carry agrees with the group's own top carry
      always_comb
        if (!$isunknown({opa_i, opb_i, cin_i}))
          p_lvl2_match_r4: assert (grp_ci[j+1] == grp_co[j]);
    end

    // R4: a generating group forces a carry into the next group
    always_comb
      if (!$isunknown({opa_i, opb_i, cin_i}) && grp_g[j])
        p_grp_gen_r4: assert (grp_ci[j+1]);
  end

  assign cout_o = grp_ci[NGRP];
  assign ovf_o  = cout_o ^ cin_bit[WIDTH-1];

  always_comb begin
    if (!$isunknown({opa_i, opb_i, cin_i})) begin
      // R3
      if (ovf_o)
        p_ovf_sign_r3: assert (opa_i[WIDTH-1] == opb_i[WIDTH-1] && sum_o[WIDTH-1] != opa_i[WIDTH-1]);
      // R5
      if (&prp && cin_i)
        p_full_chain_r5: assert (cout_o);
      // R6
      if (opa_i == '0 && opb_i == '0)
        p_zero_ops_r6: assert (sum_o == WIDTH'(cin_i) && !cout_o && !ovf_o);
    end
  end
endmodule

// File: tb/tb_cla_add2l.sv
module tb_cla_add2l;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] a, b;
  logic        ci;
  logic [31:0] s_la, s_rp;
  logic        co_la, co_rp, ov_la, ov_rp;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  cla_add2l #(.RIPPLE_GRP(1'b0)) dut (
    .opa_i(a), .opb_i(b), .cin_i(ci), .sum_o(s_la), .cout_o(co_la), .ovf_o(ov_la));
  cla_add2l #(.RIPPLE_GRP(1'b1)) dut_rip (
    .opa_i(a), .opb_i(b), .cin_i(ci), .sum_o(s_rp), .cout_o(co_rp), .ovf_o(ov_rp));

  function automatic logic [33:0] model(input logic [31:0] x, input logic [31:0] y, input logic c);
    logic [32:0] t;
    logic        v;
    t = {1'b0, x} + {1'b0, y} + {32'd0, c};
    v = (x[31] == y[31]) && (t[31] != x[31]);
    return {v, t};
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic c, input string tag);
    logic [33:0] e;
    @(posedge clk);
    #2;
    a = x; b = y; ci = c;
    #5;
    e = model(x, y, c);
    n_run++;
    if (s_la !== e[31:0] || co_la !== e[32] || ov_la !== e[33]) begin
      n_fail++;
      $display("FAIL %s (R1/R2/R3) a=%h b=%h c=%b: got s=%h co=%b ov=%b exp s=%h co=%b ov=%b",
               tag, x, y, c, s_la, co_la, ov_la, e[31:0], e[32], e[33]);
    end
    n_run++;
    if (s_rp !== s_la || co_rp !== co_la || ov_rp !== ov_la) begin
      n_fail++;
      $display("FAIL R7 %s: ripple s=%h co=%b ov=%b exp s=%h co=%b ov=%b",
               tag, s_rp, co_rp, ov_rp, s_la, co_la, ov_la);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb;
    logic        rc;
    a = '0; b = '0; ci = 1'b0;
    void'($urandom(32'd20240611));
    apply(32'd0, 32'd0, 1'b0, "R6 zero c0");
    apply(32'd0, 32'd0, 1'b1, "R6 zero c1");
    apply(32'd5, 32'd2, 1'b0, "R1 small");
    apply(32'hFFFF_FFFF, 32'd1, 1'b0, "R2 ones+1");
    apply(32'hFFFF_FFFF, 32'd0, 1'b1, "R5 ones+cin");
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R5 alt propagate");
    apply(32'h0000_00FF, 32'h0000_0001, 1'b0, "R1 boundary 8");
    apply(32'h0000_FFFF, 32'h0000_0001, 1'b0, "R1 boundary 16");
    apply(32'h00FF_FFFF, 32'h0000_0001, 1'b0, "R1 boundary 24");
    apply(32'h0000_8000, 32'h0000_8000, 1'b0, "R4 group1 generates");
    apply(32'h0080_FF00, 32'h0080_0000, 1'b0, "R4 group2 gen lower prop");
    apply(32'h7FFF_FFFF, 32'd1, 1'b0, "R3 positive overflow");
    apply(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R3 negative overflow");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R3 min+min");
    apply(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, "R3 no overflow mixed");
    for (int i = 0; i < 3000; i++) begin
      ra = $urandom; rb = $urandom; rc = 1'($urandom);
      if (i % 4 == 1) rb = ~ra;
      apply(ra, rb, rc, "R1 R2 R3 R7 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule